// File: doc/BRIEF.md
# Framed Serial Receive Channel

This block is the receive half of a framed synchronous serial port. It runs in the system clock domain. A one-cycle strobe, `bit_tick`, marks each sampling edge of the serial receive clock, which is the falling edge of that clock. On every strobe the channel looks at the frame-sync line and the data line. An accepted frame-sync starts a new word after a programmable delay of 0, 1 or 2 bit times. The channel then shifts in `WORD_W` bits, most significant bit first. Each completed word is placed in a small receive FIFO.

A host or DMA engine pops the FIFO through a plain read strobe. Two sticky status bits record error conditions. The underflow bit records a read of an empty FIFO. The overrun bit records a word that was discarded because the FIFO was full. Each status bit has its own enable, and together they drive one shared active-low interrupt line. Software clears the status bits by writing ones to them.

Frame-sync pulses are screened against the word in progress. A pulse is taken only when the next word it would start begins after the last bit of the current word. Earlier pulses are dropped, so back-to-back frames with no gap are possible and a stray pulse cannot cut a word short.

Top module: `fsrx_channel`

## Requirements
- R1: After the asynchronous reset, `rx_rdy` is 0, `status` is 0 and `irq_n` is 1.
- R2: With `dly_sel` = 0, 1 or 2, the first data bit is sampled on the same strobe as the accepted frame-sync, one strobe later, or two strobes later. Code 3 behaves like 2. The next `WORD_W` sampled bits form the word, with the first bit as the MSB.
- R3: A frame-sync is ignored in either of two cases. The first is while a start is already pending. The second is while a word is in progress and the bits still to be sampled, counting the current strobe, exceed the delay.
- R4: A frame-sync at the earliest legal strobe makes the next word start directly after the last bit of the current one. Both words are delivered intact.
- R5: `rx_rdy` is 1 exactly when the FIFO holds a word, and `rd_data` shows the oldest word. A read strobe pops words in arrival order.
- R6: A read strobe while `rx_rdy` is 0 returns 0 on `rd_data` and sets `status[0]` (underflow) on the next cycle. The bit then stays set.
- R7: A word that completes while the FIFO is full, with no pop in the same cycle, is discarded and sets `status[1]` (overrun).
- R8: A write strobe clears each status bit whose `st_wr_data` bit is 1 and leaves the others unchanged. A new event in the same cycle wins over the clear.
- R9: `irq_n` is 0 exactly when some status bit is set and its `irq_en` bit is 1.
- R10: A `rx_rst` pulse empties the FIFO and drops any word or start in progress. It leaves `status` untouched.
- R11: `ser_fs` and `ser_d` matter only on cycles where `bit_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | Strobe for one receive-clock sampling edge |
| ser_fs | input | 1 | Receive frame-sync line |
| ser_d | input | 1 | Receive data line |
| dly_sel | input | 2 | Data delay code: 0, 1, 2 (3 acts as 2) |
| rx_rst | input | 1 | Synchronous receiver reset |
| rd_en | input | 1 | Read strobe that pops the FIFO |
| rd_data | output | WORD_W | Oldest word in the FIFO, or 0 when it is empty |
| rx_rdy | output | 1 | FIFO holds at least one word |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 2 | Ones select the status bits to clear |
| irq_en | input | 2 | Interrupt enable per status bit |
| status | output | 2 | Bit 0 underflow, bit 1 overrun |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
For every delay code, the bench sweeps the second frame-sync across the strobe one before the earliest legal position, the earliest legal position itself, and the strobe after it. A block that used the wrong acceptance window would do one of two things. It would restart the first word and corrupt it, or it would lose the second word, and the words read back expose either case. The bench also drives noise on the data and sync lines between strobes. It then overfills the FIFO to show that the third word is dropped and the first two survive. It resets the receiver in the middle of a word to show that no stale bits leak into the next word. Finally it checks the status bits for set-and-clear order and for their effect on the interrupt line.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;
  localparam int ST_UNDF = 0;
  localparam int ST_OVRN = 1;
  localparam int ST_NUM  = 2;

  typedef logic [1:0] dly_code_t;

  function automatic logic [1:0] dly_clamp(input dly_code_t code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/fsrx_frame_ctrl.sv
module fsrx_frame_ctrl
  import fsrx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      tick,
  input  logic      fs,
  input  dly_code_t dly,
  output logic      cap,
  output logic      last
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic [1:0]       wait_q, wait_d;
  logic             armed_q, armed_d;

  logic             active;
  logic [1:0]       dly_eff;
  logic [CNT_W-1:0] remain;
  logic             accept;
  logic             arm_eff;
  logic [1:0]       wait_eff;

  always_comb begin
    active   = (bit_cnt_q != '0);
    dly_eff  = dly_clamp(dly);
    remain   = FULL_CNT - bit_cnt_q;
    accept   = tick && fs && !armed_q &&
               (!active || (remain <= CNT_W'(dly_eff)));
    arm_eff  = armed_q || accept;
    wait_eff = accept ? dly_eff : wait_q;

    bit_cnt_d = bit_cnt_q;
    wait_d    = wait_q;
    armed_d   = armed_q;
    cap       = 1'b0;
    last      = 1'b0;

    if (tick) begin
      if (active) begin
        cap = 1'b1;
        if (bit_cnt_q == LAST_IDX) begin
          last      = 1'b1;
          bit_cnt_d = '0;
        end else begin
          bit_cnt_d = bit_cnt_q + 1'b1;
        end
      end
      if (arm_eff) begin
        if (wait_eff == 2'd0) begin
          cap       = 1'b1;
          bit_cnt_d = CNT_W'(1);
          armed_d   = 1'b0;
          wait_d    = 2'd0;
        end else begin
          armed_d = 1'b1;
          wait_d  = wait_eff - 2'd1;
        end
      end
    end

    if (clr) begin
      bit_cnt_d = '0;
      wait_d    = 2'd0;
      armed_d   = 1'b0;
      cap       = 1'b0;
      last      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      wait_q    <= 2'd0;
      armed_q   <= 1'b0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      wait_q    <= wait_d;
      armed_q   <= armed_d;
    end
  end
endmodule

// File: rtl/fsrx_shifter.sv
module fsrx_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    word = {sh_q[WORD_W-2:0], din};
    sh_d = sh_q;
    if (clr)      sh_d = '0;
    else if (cap) sh_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/fsrx_fifo.sv
module fsrx_fifo #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_push, do_pop;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CNT_W'(DEPTH));
    do_pop  = pop && !empty;
    do_push = push && (!full || do_pop);
    head    = empty ? '0 : mem_q[rp_q];

    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mem_q[g] <= '0;
      else if (do_push && !clr && wp_q == PTR_W'(g)) mem_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/fsrx_channel.sv
module fsrx_channel
  import fsrx_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int BUF_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              ser_fs,
  input  logic              ser_d,
  input  logic [1:0]        dly_sel,
  input  logic              rx_rst,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_rdy,
  input  logic              st_wr_en,
  input  logic [1:0]        st_wr_data,
  input  logic [1:0]        irq_en,
  output logic [1:0]        status,
  output logic              irq_n
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic              cap, last;
  logic [WORD_W-1:0] word;
  logic              fifo_empty, fifo_full;
  logic              push, pop;

  fsrx_frame_ctrl #(.WORD_W(WORD_W)) u_frame (
    .clk  (clk),
    .rst_n(rst_n_int),
    .clr  (rx_rst),
    .tick (bit_tick),
    .fs   (ser_fs),
    .dly  (dly_sel),
    .cap  (cap),
    .last (last)
  );

  fsrx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n_int),
    .clr  (rx_rst),
    .cap  (cap),
    .din  (ser_d),
    .word (word)
  );

  assign push = last && !rx_rst;
  assign pop  = rd_en && !rx_rst;

  fsrx_fifo #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n_int),
    .clr  (rx_rst),
    .push (push),
    .wdata(word),
    .pop  (pop),
    .head (rd_data),
    .empty(fifo_empty),
    .full (fifo_full)
  );

  assign rx_rdy = !fifo_empty;

  logic [ST_NUM-1:0] st_q, st_d, st_set, st_clr;

  always_comb begin
    st_set          = '0;
    st_set[ST_UNDF] = rd_en && fifo_empty;
    st_set[ST_OVRN] = push && fifo_full && !(pop && !fifo_empty);
    st_clr          = st_wr_en ? st_wr_data : '0;
    st_d            = (st_q & ~st_clr) | st_set;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) st_q <= '0;
    else            st_q <= st_d;
  end

  assign status = st_q;
  assign irq_n  = ~|(st_q & irq_en);
endmodule

// File: rtl/fsrx_channel_chk.sv
module fsrx_channel_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       bit_tick,
  input logic       rx_rst,
  input logic       rd_en,
  input logic       rx_rdy,
  input logic       st_wr_en,
  input logic [1:0] st_wr_data,
  input logic [1:0] irq_en,
  input logic [1:0] status,
  input logic       irq_n
);
  // R6
  underflow_sets_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_en && !rx_rdy |=> status[0]);

  // R9
  undf_irq_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_en && !rx_rdy && irq_en[0] |=> (!irq_n || !irq_en[0]));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    st_wr_en && st_wr_data[0] && !(rd_en && !rx_rdy) |=> !status[0]);

  // R8
  w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    st_wr_en && (st_wr_data == 2'b00) |=> ((status & $past(status)) == $past(status)));

  // R10
  rxrst_empty_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_rst |=> !rx_rdy);

  // R10
  rxrst_keep_status_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_rst && !st_wr_en |=> ((status & $past(status)) == $past(status)));

  // R11
  no_tick_no_word_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !rx_rdy && !bit_tick |=> !rx_rdy);
endmodule

bind fsrx_channel fsrx_channel_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_int),
  .bit_tick  (bit_tick),
  .rx_rst    (rx_rst),
  .rd_en     (rd_en),
  .rx_rdy    (rx_rdy),
  .st_wr_en  (st_wr_en),
  .st_wr_data(st_wr_data),
  .irq_en    (irq_en),
  .status    (status),
  .irq_n     (irq_n)
);

// File: tb/tb_fsrx_channel.sv
`timescale 1ns/1ps
module tb_fsrx_channel;
  localparam int W = 8;
  localparam int N = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bit_tick = 1'b0, ser_fs = 1'b0, ser_d = 1'b0;
  logic [1:0]   dly_sel = 2'd0;
  logic         rx_rst = 1'b0, rd_en = 1'b0, st_wr_en = 1'b0;
  logic [1:0]   st_wr_data = 2'b00, irq_en = 2'b00;
  logic [W-1:0] rd_data;
  logic         rx_rdy, irq_n;
  logic [1:0]   status;

  int n_chk = 0;
  int n_fail = 0;
  logic fs_arr [N];
  logic db_arr [N];

  always #4 clk = ~clk;

  fsrx_channel #(.WORD_W(W), .BUF_DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ser_fs(ser_fs), .ser_d(ser_d),
    .dly_sel(dly_sel), .rx_rst(rx_rst), .rd_en(rd_en), .rd_data(rd_data),
    .rx_rdy(rx_rdy), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .irq_en(irq_en), .status(status), .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_stream();
    for (int i = 0; i < N; i++) begin
      fs_arr[i] = 1'b0;
      db_arr[i] = 1'b0;
    end
  endtask

  task automatic add_frame(input int fst, input int d, input logic [W-1:0] w, input int min_idx);
    fs_arr[fst] = 1'b1;
    for (int i = 0; i < W; i++)
      if (fst + d + i > min_idx && fst + d + i < N) db_arr[fst + d + i] = w[W-1-i];
  endtask

  task automatic play(input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      bit_tick = 1'b1; ser_fs = fs_arr[t]; ser_d = db_arr[t];
      @(negedge clk);
      bit_tick = 1'b0; ser_fs = 1'b1; ser_d = ~db_arr[t];
      @(negedge clk);
      ser_fs = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(output logic [W-1:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic wr_status(input logic [1:0] v);
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_data = v;
    @(negedge clk);
    st_wr_en = 1'b0; st_wr_data = 2'b00;
    #1;
  endtask

  task automatic pulse_rxrst();
    @(negedge clk);
    rx_rst = 1'b1;
    @(negedge clk);
    rx_rst = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, v;
    int deff, last_a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk(rx_rdy == 1'b0, "R1 rdy", 32'(rx_rdy), 0);
    chk(status == 2'b00, "R1 status", 32'(status), 0);
    chk(irq_n == 1'b1, "R1 irq_n", 32'(irq_n), 1);

    // R2 R3 R4 R11 sweep: delay code x second-sync offset
    for (int ds = 0; ds < 4; ds++) begin
      for (int dl = -1; dl <= 1; dl++) begin
        deff = (ds == 3) ? 2 : ds;
        a = W'(8'h3C + ds * 29 + (dl + 1) * 71);
        b = W'(a * 3 + 8'h51);
        last_a = 2 + deff + W - 1;
        clear_stream();
        add_frame(2, deff, a, -1);
        add_frame(last_a + 1 - deff + dl, deff, b, last_a);
        dly_sel = 2'(ds);
        play(26);
        chk(rx_rdy == 1'b1, "R5 rdy after word", 32'(rx_rdy), 1);
        do_read(v);
        chk(v == a, "R2 first word", 32'(v), 32'(a));
        if (dl >= 0) begin
          do_read(v);
          chk(v == b, "R4 back-to-back word", 32'(v), 32'(b));
        end
        chk(rx_rdy == 1'b0, "R3 no extra word", 32'(rx_rdy), 0);
        chk(status == 2'b00, "R3 no error", 32'(status), 0);
      end
    end

    // R7 overrun: three frames into a two-entry buffer
    dly_sel = 2'd0;
    clear_stream();
    add_frame(0, 0, 8'h11, -1);
    add_frame(10, 0, 8'h22, -1);
    add_frame(20, 0, 8'h33, -1);
    play(30);
    chk(status == 2'b10, "R7 overrun flag", 32'(status), 32'h2);
    irq_en = 2'b10;
    #1 chk(irq_n == 1'b0, "R9 overrun irq enabled", 32'(irq_n), 0);
    irq_en = 2'b01;
    #1 chk(irq_n == 1'b1, "R9 overrun irq masked", 32'(irq_n), 1);
    do_read(v);
    chk(v == 8'h11, "R5 order first", 32'(v), 32'h11);
    do_read(v);
    chk(v == 8'h22, "R7 second kept", 32'(v), 32'h22);
    chk(rx_rdy == 1'b0, "R7 third dropped", 32'(rx_rdy), 0);

    // R8 write-one-to-clear
    wr_status(2'b00);
    chk(status == 2'b10, "R8 write zero keeps", 32'(status), 32'h2);
    wr_status(2'b01);
    chk(status == 2'b10, "R8 other bit kept", 32'(status), 32'h2);
    wr_status(2'b10);
    chk(status == 2'b00, "R8 write one clears", 32'(status), 0);

    // R6 underflow
    @(negedge clk);
    rd_en = 1'b1;
    #1 chk(rd_data == '0, "R6 empty read data", 32'(rd_data), 0);
    @(negedge clk);
    rd_en = 1'b0;
    #1 chk(status == 2'b01, "R6 underflow set", 32'(status), 1);
    chk(irq_n == 1'b0, "R9 underflow irq", 32'(irq_n), 0);
    repeat (3) @(negedge clk);
    #1 chk(status == 2'b01, "R6 sticky", 32'(status), 1);

    // R10 receiver reset keeps status, empties buffer
    clear_stream();
    add_frame(0, 0, 8'hC3, -1);
    play(10);
    chk(rx_rdy == 1'b1, "R5 word present", 32'(rx_rdy), 1);
    pulse_rxrst();
    chk(rx_rdy == 1'b0, "R10 buffer emptied", 32'(rx_rdy), 0);
    chk(status == 2'b01, "R10 status kept", 32'(status), 1);

    // R10 reset mid-word: no stale bits
    dly_sel = 2'd1;
    clear_stream();
    add_frame(0, 1, 8'hFF, -1);
    play(5);
    pulse_rxrst();
    clear_stream();
    add_frame(1, 1, 8'h5A, -1);
    play(12);
    do_read(v);
    chk(v == 8'h5A, "R10 clean word after reset", 32'(v), 32'h5A);

    wr_status(2'b11);
    chk(irq_n == 1'b1, "R9 irq released", 32'(irq_n), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule